// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block executes the commands that software issues to a hot-plug controller. It serves up to 31 slots. Software loads a command byte and a target byte through a byte write port, then pulses a start strobe. The engine finishes each command in a single clock cycle. After that cycle the per-slot status words, the command status bits and the bus speed field show the result.

For each slot the engine keeps four things: the slot state, the power indicator and the attention indicator, the MRL-open flag with its presence code, and three latched events. A slot command moves one slot through the legal state changes and sets its indicators. When a slot is disabled with its power indicator off, the engine marks the slot as emptied. Two group commands, power-only-all and enable-all, first check that no slot is enabled. They then act on every slot at once, according to whether that slot's MRL is closed. A bus speed command accepts only the conventional 33 MHz setting.

A synchronous reset loads each slot from the `occupied_i` vector. A slot with a card in it starts enabled. An empty slot starts disabled and marked open.

Top module: `hpc_cmd_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine loads its reset state. An occupied slot becomes state 2 with power indicator 1, MRL closed and presence 0. An empty slot becomes state 3 with power indicator 3, MRL open and presence 3. Attention indicators, events, command status, bus speed, command byte, target byte and the done flag all become zero.
- R2: `rd_status` shows the slot selected by `rd_sel` with this layout: state in bits 1:0, power indicator in bits 3:2, attention indicator in bits 5:4, MRL-open in bit 8, presence in bits 11:10, and every other bit zero. `rd_event` shows the presence event in bit 0, the button event in bit 2 and the MRL event in bit 3.
- R3: A slot command is any command byte from 0x00 to 0x3F. Its bits 1:0 give the requested state, using none=0, power-only=1, enabled=2, disabled=3. The slot state changes only in three cases: disabled to power-only, disabled to enabled, or enabled/power-only to disabled. Every other request leaves the state unchanged.
- R4: In a slot command, bits 3:2 give the power indicator and bits 5:4 give the attention indicator, using keep=0, on=1, blink=2, off=3. A nonzero field replaces that indicator. A zero field leaves it unchanged.
- R5: A request that takes an enabled slot to power-only sets invalid-command, which is `cmd_status` bit 2. The slot is left completely unchanged.
- R6: The target byte is written with `wr_addr`=1 and is kept to its low 5 bits. The slot index is the target minus 1. A target of 0, or a target above the slot count, sets invalid-command and changes no slot.
- R7: A slot can enter the disabled state with its power indicator off, where the indicator value is taken after this command's own indicator field is applied. In that case the slot also becomes MRL-open with presence 3, and its button, MRL and presence events latch to 1.
- R8: Each command first clears `cmd_status` bits 3:0: busy, MRL-open, invalid-command and invalid-mode. When the command finishes, `cmd_done` is set, and it stays set until reset.
- R9: Command bytes 0x40 to 0x47 set the bus speed, taking the speed from the low 3 bits. Speed 0 is accepted into `bus_speed`. Any other speed sets invalid-mode, which is `cmd_status` bit 3, and leaves `bus_speed` unchanged.
- R10: If any slot is enabled, group power-only (0x48) and group enable (0x49) set invalid-command and change no slot.
- R11: Otherwise, a group command asks each slot whose MRL is closed for the group state, power-only or enabled, with the power indicator on. It asks each slot whose MRL is open for state none with the power indicator off. The transition rules of R3 apply to every one of these requests.
- R12: A command byte above 0x49 sets invalid-command and changes nothing else.
- R13: The command byte is written with `wr_addr`=0. A register write only stores the byte. Only `cmd_start` runs a command, and it uses the bytes held before that clock edge. With `cmd_start` low, no slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| occupied_i | input | NSLOTS | Slot occupancy, sampled during reset |
| wr_en | input | 1 | Register byte write enable |
| wr_addr | input | 1 | 0 selects the command byte, 1 selects the target byte |
| wr_data | input | 8 | Write data |
| cmd_start | input | 1 | Runs the stored command |
| rd_sel | input | IDX_W | Slot index for the read port |
| rd_status | output | 16 | Status word of the selected slot |
| rd_event | output | 5 | Latched events of the selected slot |
| cmd_status | output | 4 | Command status bits |
| cmd_done | output | 1 | Command-detected flag |
| bus_speed | output | 3 | Secondary bus speed field |

## Verification
The bench targets the following corner cases, and for each it names what a faulty design would show:
- **Enabled to power-only.** An engine that is missing the rejection would move the slot to power-only, or would update its indicators anyway.
- **Disable with the power indicator off.** The check uses the indicator value written in the same command. A design that read the old indicator would not empty the slot.
- **Target boundaries.** Targets of 0, slot count plus one, and a byte with high bits set are all exercised. A design that got these wrong would corrupt slot 0 or a phantom slot.
- **Group commands.** They are run with an enabled slot present and with mixed MRL states. They are also run on a power-only slot, which must not jump straight to enabled.
- **Status bit clearing.** A design that failed to clear status bits would carry an invalid flag into the next command.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam int TGT_W = 5;

    typedef enum logic [1:0] {
        ST_NONE     = 2'd0,
        ST_PWRONLY  = 2'd1,
        ST_ENABLED  = 2'd2,
        ST_DISABLED = 2'd3
    } slot_state_e;

    typedef enum logic [1:0] {
        IND_KEEP  = 2'd0,
        IND_ON    = 2'd1,
        IND_BLINK = 2'd2,
        IND_OFF   = 2'd3
    } ind_e;

    typedef enum logic [2:0] {
        OP_SLOT,
        OP_SPEED,
        OP_GRP_PWR,
        OP_GRP_EN,
        OP_BAD
    } op_e;

    localparam logic [1:0] PRES_EMPTY = 2'd3;
    localparam logic [1:0] PRES_LOW   = 2'd0;

    localparam int CST_INV_CMD  = 2;
    localparam int CST_INV_MODE = 3;

    // evt[2] = MRL event, evt[1] = button event, evt[0] = presence event
    typedef struct packed {
        logic [2:0]  evt;
        logic [1:0]  presence;
        logic        mrl_open;
        ind_e        attn;
        ind_e        pwr;
        slot_state_e state;
    } slot_t;

    function automatic logic [15:0] pack_status(input slot_t s);
        return {4'b0000, s.presence, 1'b0, s.mrl_open, 2'b00, s.attn, s.pwr, s.state};
    endfunction

    function automatic logic [4:0] pack_event(input slot_t s);
        return {1'b0, s.evt[2], s.evt[1], 1'b0, s.evt[0]};
    endfunction

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
    import hpc_pkg::*;
(
    input  logic [7:0]  code,
    output op_e         op,
    output slot_state_e req_state,
    output ind_e        req_pwr,
    output ind_e        req_attn,
    output logic [2:0]  speed
);

    always_comb begin
        if (code[7:6] == 2'b00) begin
            op = OP_SLOT;
        end else if (code[7:3] == 5'b01000) begin
            op = OP_SPEED;
        end else if (code == 8'h48) begin
            op = OP_GRP_PWR;
        end else if (code == 8'h49) begin
            op = OP_GRP_EN;
        end else begin
            op = OP_BAD;
        end
        req_state = slot_state_e'(code[1:0]);
        req_pwr   = ind_e'(code[3:2]);
        req_attn  = ind_e'(code[5:4]);
        speed     = code[2:0];
    end

endmodule

// File: rtl/hpc_slot_next.sv
module hpc_slot_next
    import hpc_pkg::*;
(
    input  slot_t       cur,
    input  logic        apply,
    input  slot_state_e req_state,
    input  ind_e        req_pwr,
    input  ind_e        req_attn,
    output slot_t       nxt,
    output logic        reject
);

    always_comb begin
        nxt    = cur;
        reject = apply && (cur.state == ST_ENABLED) && (req_state == ST_PWRONLY);
        if (apply && !reject) begin
            if (req_pwr != IND_KEEP) begin
                nxt.pwr = req_pwr;
            end
            if (req_attn != IND_KEEP) begin
                nxt.attn = req_attn;
            end
            if ((cur.state == ST_DISABLED) &&
                ((req_state == ST_PWRONLY) || (req_state == ST_ENABLED))) begin
                nxt.state = req_state;
            end else if (((cur.state == ST_ENABLED) || (cur.state == ST_PWRONLY)) &&
                         (req_state == ST_DISABLED)) begin
                nxt.state = ST_DISABLED;
                // indicator value after this command's own field is applied
                if (nxt.pwr == IND_OFF) begin
                    nxt.mrl_open = 1'b1;
                    nxt.presence = PRES_EMPTY;
                    nxt.evt      = cur.evt | 3'b111;
                end
            end
        end
    end

endmodule

// File: rtl/hpc_cmd_engine.sv
module hpc_cmd_engine
    import hpc_pkg::*;
#(
    parameter int NSLOTS = 31,
    localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOTS-1:0] occupied_i,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cmd_start,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [15:0]       rd_status,
    output logic [4:0]        rd_event,
    output logic [3:0]        cmd_status,
    output logic              cmd_done,
    output logic [2:0]        bus_speed
);

    typedef struct packed {
        slot_t [NSLOTS-1:0] slots;
        logic [7:0]         code;
        logic [TGT_W-1:0]   tgt;
        logic [3:0]         cst;
        logic [2:0]         speed;
        logic               det;
    } regs_t;

    regs_t regs_q, regs_d, regs_rst;

    op_e         dec_op;
    slot_state_e dec_state;
    ind_e        dec_pwr;
    ind_e        dec_attn;
    logic [2:0]  dec_speed;

    hpc_cmd_decode u_decode (
        .code      (regs_q.code),
        .op        (dec_op),
        .req_state (dec_state),
        .req_pwr   (dec_pwr),
        .req_attn  (dec_attn),
        .speed     (dec_speed)
    );

    logic             tgt_ok;
    logic [TGT_W-1:0] tgt_idx;
    logic             is_grp;
    logic             any_enabled;
    slot_state_e      grp_state;

    assign tgt_ok    = (regs_q.tgt != '0) && (int'(regs_q.tgt) <= NSLOTS);
    assign tgt_idx   = regs_q.tgt - TGT_W'(1);
    assign is_grp    = (dec_op == OP_GRP_PWR) || (dec_op == OP_GRP_EN);
    assign grp_state = (dec_op == OP_GRP_PWR) ? ST_PWRONLY : ST_ENABLED;

    always_comb begin
        any_enabled = 1'b0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (regs_q.slots[i].state == ST_ENABLED) begin
                any_enabled = 1'b1;
            end
        end
    end

    slot_t [NSLOTS-1:0] slot_nxt;
    logic  [NSLOTS-1:0] slot_rej;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        logic        apply_g;
        slot_state_e rstate_g;
        ind_e        rpwr_g;
        ind_e        rattn_g;

        assign apply_g = cmd_start &&
                         (((dec_op == OP_SLOT) && tgt_ok && (tgt_idx == TGT_W'(g))) ||
                          (is_grp && !any_enabled));
        assign rstate_g = is_grp ? (regs_q.slots[g].mrl_open ? ST_NONE : grp_state) : dec_state;
        assign rpwr_g   = is_grp ? (regs_q.slots[g].mrl_open ? IND_OFF : IND_ON) : dec_pwr;
        assign rattn_g  = is_grp ? IND_KEEP : dec_attn;

        hpc_slot_next u_slot (
            .cur       (regs_q.slots[g]),
            .apply     (apply_g),
            .req_state (rstate_g),
            .req_pwr   (rpwr_g),
            .req_attn  (rattn_g),
            .nxt       (slot_nxt[g]),
            .reject    (slot_rej[g])
        );

        // R5: an enabled slot never becomes power-only in one step
        assert_no_en_to_po_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_q.slots[g].state == ST_ENABLED) |=> (regs_q.slots[g].state != ST_PWRONLY));

        // R7: MRL-open and empty presence always travel together
        assert_empty_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
            regs_q.slots[g].mrl_open == (regs_q.slots[g].presence == PRES_EMPTY));
    end

    always_comb begin
        regs_rst = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (occupied_i[i]) begin
                regs_rst.slots[i].state    = ST_ENABLED;
                regs_rst.slots[i].pwr      = IND_ON;
                regs_rst.slots[i].mrl_open = 1'b0;
                regs_rst.slots[i].presence = PRES_LOW;
            end else begin
                regs_rst.slots[i].state    = ST_DISABLED;
                regs_rst.slots[i].pwr      = IND_OFF;
                regs_rst.slots[i].mrl_open = 1'b1;
                regs_rst.slots[i].presence = PRES_EMPTY;
            end
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (cmd_start) begin
            regs_d.cst = '0;
            regs_d.det = 1'b1;
            unique case (dec_op)
                OP_SLOT: begin
                    if (!tgt_ok) begin
                        regs_d.cst[CST_INV_CMD] = 1'b1;
                    end else begin
                        regs_d.slots = slot_nxt;
                        if (|slot_rej) begin
                            regs_d.cst[CST_INV_CMD] = 1'b1;
                        end
                    end
                end
                OP_SPEED: begin
                    if (dec_speed == 3'd0) begin
                        regs_d.speed = dec_speed;
                    end else begin
                        regs_d.cst[CST_INV_MODE] = 1'b1;
                    end
                end
                OP_GRP_PWR, OP_GRP_EN: begin
                    if (any_enabled) begin
                        regs_d.cst[CST_INV_CMD] = 1'b1;
                    end else begin
                        regs_d.slots = slot_nxt;
                    end
                end
                default: begin
                    regs_d.cst[CST_INV_CMD] = 1'b1;
                end
            endcase
        end
        if (wr_en) begin
            if (wr_addr) begin
                regs_d.tgt = wr_data[TGT_W-1:0];
            end else begin
                regs_d.code = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= regs_rst;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_status = '0;
        rd_event  = '0;
        if (int'(rd_sel) < NSLOTS) begin
            rd_status = pack_status(regs_q.slots[rd_sel]);
            rd_event  = pack_event(regs_q.slots[rd_sel]);
        end
    end

    assign cmd_status = regs_q.cst;
    assign cmd_done   = regs_q.det;
    assign bus_speed  = regs_q.speed;

    // R13: slots hold when no command starts
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_start |=> $stable(regs_q.slots));

    // R8: every started command leaves the done flag set
    assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> cmd_done);

    // R6: a bad target flags invalid-command and touches no slot
    assert_bad_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && (dec_op == OP_SLOT) && !tgt_ok) |=> (cmd_status[CST_INV_CMD] && $stable(regs_q.slots)));

    // R9: a nonzero speed flags invalid-mode
    assert_bad_speed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && (dec_op == OP_SPEED) && (dec_speed != 3'd0)) |=> cmd_status[CST_INV_MODE]);

    // R10: group command with an enabled slot leaves the slots alone
    assert_grp_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && is_grp && any_enabled) |=> (cmd_status[CST_INV_CMD] && $stable(regs_q.slots)));

endmodule

// File: tb/hpc_cmd_engine_test.sv
`timescale 1ns/1ps
module hpc_cmd_engine_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] occupied = 4'b0101;
    logic         wr_en = 1'b0;
    logic         wr_addr = 1'b0;
    logic [7:0]   wr_data = '0;
    logic         cmd_start = 1'b0;
    logic [1:0]   rd_sel = '0;
    logic [15:0]  rd_status;
    logic [4:0]   rd_event;
    logic [3:0]   cmd_status;
    logic         cmd_done;
    logic [2:0]   bus_speed;

    always #2 clk = ~clk;

    hpc_cmd_engine #(.NSLOTS(N)) uut (
        .clk(clk), .rst_n(rst_n), .occupied_i(occupied),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_start(cmd_start), .rd_sel(rd_sel),
        .rd_status(rd_status), .rd_event(rd_event),
        .cmd_status(cmd_status), .cmd_done(cmd_done), .bus_speed(bus_speed)
    );

    int checks = 0;
    int errors = 0;

    int ms[N], mp[N], ma[N], mm[N], mpr[N], me[N];
    int mcst, mdet, mspd, mcode, mtgt;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            if (occupied[i]) begin ms[i] = 2; mp[i] = 1; mm[i] = 0; mpr[i] = 0; end
            else begin ms[i] = 3; mp[i] = 3; mm[i] = 1; mpr[i] = 3; end
            ma[i] = 0; me[i] = 0;
        end
        mcst = 0; mdet = 0; mspd = 0; mcode = 0; mtgt = 0;
    endtask

    task automatic mslot(input int i, input int rs, input int rp, input int ra, output bit rej);
        rej = 1'b0;
        if (ms[i] == 2 && rs == 1) begin
            rej = 1'b1;
        end else begin
            if (rp != 0) mp[i] = rp;
            if (ra != 0) ma[i] = ra;
            if (ms[i] == 3 && (rs == 1 || rs == 2)) begin
                ms[i] = rs;
            end else if ((ms[i] == 2 || ms[i] == 1) && rs == 3) begin
                ms[i] = 3;
                if (mp[i] == 3) begin mm[i] = 1; mpr[i] = 3; me[i] = me[i] | 'h0D; end
            end
        end
    endtask

    task automatic model_edge(input bit we, input bit wa, input int wd, input bit go);
        bit rej;
        bit anyen;
        if (go) begin
            mcst = 0;
            mdet = 1;
            if (mcode < 'h40) begin
                if (mtgt == 0 || mtgt - 1 >= N) mcst = mcst | 4;
                else begin
                    mslot(mtgt - 1, mcode % 4, (mcode / 4) % 4, (mcode / 16) % 4, rej);
                    if (rej) mcst = mcst | 4;
                end
            end else if (mcode < 'h48) begin
                if (mcode % 8 == 0) mspd = 0;
                else mcst = mcst | 8;
            end else if (mcode == 'h48 || mcode == 'h49) begin
                anyen = 1'b0;
                for (int i = 0; i < N; i++) if (ms[i] == 2) anyen = 1'b1;
                if (anyen) mcst = mcst | 4;
                else for (int i = 0; i < N; i++) begin
                    if (mm[i] == 0) mslot(i, (mcode == 'h48) ? 1 : 2, 1, 0, rej);
                    else mslot(i, 0, 3, 0, rej);
                end
            end else begin
                mcst = mcst | 4;
            end
        end
        if (we) begin
            if (wa) mtgt = wd % 32;
            else mcode = wd;
        end
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < N; i++) begin
            rd_sel = 2'(i);
            #0.2;
            check(tag, $sformatf("slot%0d status", i), int'(rd_status),
                  ms[i] + mp[i] * 4 + ma[i] * 16 + mm[i] * 256 + mpr[i] * 1024);
            check(tag, $sformatf("slot%0d event", i), int'(rd_event), me[i]);
        end
        check(tag, "cmd_status", int'(cmd_status), mcst);
        check(tag, "cmd_done", int'(cmd_done), mdet);
        check(tag, "bus_speed", int'(bus_speed), mspd);
    endtask

    task automatic cyc(input string tag, input bit we, input bit wa, input logic [7:0] wd, input bit go);
        wr_en = we; wr_addr = wa; wr_data = wd; cmd_start = go;
        @(posedge clk);
        model_edge(we, wa, int'(wd), go);
        @(negedge clk);
        wr_en = 1'b0; cmd_start = 1'b0;
        compare_all(tag);
    endtask

    task automatic cmd(input string tag, input logic [7:0] tgt, input logic [7:0] code);
        cyc(tag, 1'b1, 1'b1, tgt, 1'b0);
        cyc(tag, 1'b1, 1'b0, code, 1'b0);
        cyc(tag, 1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic peek(input string tag, input int slot, input int exp_status, input int exp_evt);
        rd_sel = 2'(slot);
        #0.2;
        check(tag, "literal status", int'(rd_status), exp_status);
        check(tag, "literal event", int'(rd_event), exp_evt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        model_reset();
        compare_all("R1 reset");
        peek("R1 occupied slot", 0, 'h0006, 0);
        peek("R1 empty slot", 1, 'h0D0F, 0);
        rst_n = 1'b1;

        // R13: writes alone do nothing
        cyc("R13 write target", 1'b1, 1'b1, 8'h02, 1'b0);
        cyc("R13 write code", 1'b1, 1'b0, 8'h1A, 1'b0);
        cyc("R13 idle", 1'b0, 1'b0, 8'h00, 1'b0);
        // R3/R4: disabled -> enabled, power blink, attention on
        cyc("R3 enable slot1", 1'b0, 1'b0, 8'h00, 1'b1);
        peek("R2 status layout", 1, 'h0D1A, 0);

        cmd("R5 enabled to power-only", 8'h01, 8'h05);
        cmd("R4 attention only", 8'h01, 8'h30);
        cmd("R8 status cleared", 8'h01, 8'h00);
        cmd("R6 target zero", 8'h00, 8'h02);
        cmd("R6 target past end", 8'h05, 8'h0F);
        cmd("R6 target masked", 8'h21, 8'h0F);
        peek("R7 removal fields", 0, 'h0D3F, 'h0D);
        cmd("R3 disable keeps presence", 8'h02, 8'h03);
        cmd("R3 none request", 8'h02, 8'h00);
        cmd("R9 speed zero", 8'h02, 8'h40);
        cmd("R9 speed bad", 8'h02, 8'h43);
        cmd("R12 code 0x4A", 8'h02, 8'h4A);
        cmd("R12 code 0x80", 8'h02, 8'h80);
        cmd("R10 group with enabled slot", 8'h02, 8'h49);
        cmd("R3 disable slot2", 8'h03, 8'h03);
        cmd("R11 group enable", 8'h03, 8'h49);
        cmd("R10 group power-only blocked", 8'h03, 8'h48);
        cmd("R3 disable slot2 again", 8'h03, 8'h03);
        cmd("R11 group power-only", 8'h03, 8'h48);
        cmd("R11 power-only stays on group enable", 8'h03, 8'h49);
        cmd("R3 power-only to disabled with off", 8'h03, 8'h0F);

        // R1: reset again with other occupancy
        @(negedge clk);
        rst_n = 1'b0;
        occupied = 4'b1010;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        compare_all("R1 second reset");
        rst_n = 1'b1;
        cmd("R11 group power-only after reset", 8'h01, 8'h48);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule